// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block is the hazard control unit for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no operand forwarding. Each cycle it looks at the source registers that the decode-stage instruction reads. It also looks at the destination register and write enable of the instructions in execute and memory. A match against either producer freezes the program counter and the fetch/decode register and sends a no-op into execute. The instructions already in execute, memory and writeback keep moving.

The register file writes early in the cycle and reads late. A producer that has reached writeback therefore no longer blocks a consumer. An adjacent dependency costs two bubbles, a gap of one instruction costs one, and a gap of two costs none.

Branches resolve in the memory stage. A correct prediction costs nothing. A misprediction kills the three younger instructions in fetch/decode, execute and memory, and redirects fetch to the corrected target. A flush overrides a stall in the same cycle. The unit is purely combinational and sits between the pipeline registers and their enables.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When a used decode source equals the execute-stage destination, and that instruction writes a nonzero register, `hold_fetch` and `kill_ex` are 1 unless a misprediction is reported.
- R2: The same holds for a match against the memory-stage destination with its write enable high.
- R3: When no used decode source matches an execute or memory producer, `hold_fetch` and `kill_ex` are 0. An instruction in writeback is never presented, so it never blocks.
- R4: Destination register 0 never causes a stall, even with its write enable high and a matching source.
- R5: A producer whose write enable is 0 never causes a stall. A source whose use flag is 0 never causes a stall.
- R6: Driven through a pipeline that obeys the outputs, a consumer at distance 1, 2 or 3 behind its producer sees 2, 1 or 0 stall cycles. A second consumer of the same producer, right behind the first, adds no stall.
- R7: A branch resolved as correctly predicted (`br_done`=1, `br_miss`=0) raises none of `kill_id`, `kill_mem` and `redirect`.
- R8: A mispredicted branch (`br_done`=1, `br_miss`=1) raises `kill_id`, `kill_ex`, `kill_mem` and `redirect` in the same cycle. Without `br_done`, `br_miss` has no effect.
- R9: When a misprediction and a data hazard occur in one cycle, `hold_fetch` is 0 and `kill_id` is 1, so the stalled decode instruction is discarded.
- R10: Every decode source port (index 0 in bits AW-1:0, index 1 above it) triggers a stall on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_src | input | NSRC*AW | Decode-stage source register numbers, source s in bits s*AW +: AW |
| id_src_use | input | NSRC | 1 when the matching source is really read |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes the register file |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes the register file |
| br_done | input | 1 | A branch in the memory stage resolved this cycle |
| br_miss | input | 1 | That branch was mispredicted |
| hold_fetch | output | 1 | Hold the program counter and the fetch/decode register |
| kill_id | output | 1 | Clear the fetch/decode register |
| kill_ex | output | 1 | Load a no-op into the decode/execute register |
| kill_mem | output | 1 | Load a no-op into the execute/memory register |
| redirect | output | 1 | Load the program counter with the corrected target |

## Verification
A data hazard and a branch misprediction can fall in the same cycle. Priority then decides whether fetch holds or moves to the new target. The bench sweeps every combination of a 2-bit register space, both sources, both producers and both branch inputs, and so reaches every way the two collide. In each collision it expects no hold with all three kills and the redirect raised. A separate run feeds short instruction streams through a model pipeline that obeys the outputs, and counts the stall cycles at each producer distance.

// File: rtl/phc_pkg.sv
`timescale 1ns/1ps
package phc_pkg;

  // Controls returned to the pipeline registers.
  typedef struct packed {
    logic hold_fetch;
    logic kill_id;
    logic kill_ex;
    logic kill_mem;
    logic redirect;
  } phc_ctl_t;

  localparam int unsigned PHC_CTL_W = $bits(phc_ctl_t);

endpackage

// File: rtl/phc_match.sv
`timescale 1ns/1ps
// Compares one consumer source with one in-flight producer.
module phc_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          src_use,
  input  logic [AW-1:0] dst,
  input  logic          dst_wr,
  output logic          hit
);
  logic dst_live;

  always_comb begin
    dst_live = dst_wr & (dst != '0);
    hit      = src_use & dst_live & (src == dst);
  end
endmodule

// File: rtl/phc_raw_detect.sv
`timescale 1ns/1ps
// Read-after-write check of every decode source against execute and memory.
module phc_raw_detect #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC*AW-1:0] id_src,
  input  logic [NSRC-1:0]    id_src_use,
  input  logic [AW-1:0]      ex_dst,
  input  logic               ex_wr,
  input  logic [AW-1:0]      mem_dst,
  input  logic               mem_wr,
  output logic               raw_hit
);
  localparam int unsigned NPROD = 2;

  logic [NSRC-1:0] hit_ex;
  logic [NSRC-1:0] hit_mem;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    phc_match #(.AW(AW)) u_ex (
      .src     (id_src[s*AW +: AW]),
      .src_use (id_src_use[s]),
      .dst     (ex_dst),
      .dst_wr  (ex_wr),
      .hit     (hit_ex[s])
    );
    phc_match #(.AW(AW)) u_mem (
      .src     (id_src[s*AW +: AW]),
      .src_use (id_src_use[s]),
      .dst     (mem_dst),
      .dst_wr  (mem_wr),
      .hit     (hit_mem[s])
    );
  end

  logic [NPROD*NSRC-1:0] all_hits;

  always_comb begin
    all_hits = {hit_mem, hit_ex};
    raw_hit  = |all_hits;
  end
endmodule

// File: rtl/phc_redirect.sv
`timescale 1ns/1ps
// Qualifies the branch outcome from the memory stage.
module phc_redirect (
  input  logic br_done,
  input  logic br_miss,
  output logic wrong_path
);
  always_comb begin
    wrong_path = br_done & br_miss;
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC*AW-1:0] id_src,
  input  logic [NSRC-1:0]    id_src_use,
  input  logic [AW-1:0]      ex_dst,
  input  logic               ex_wr,
  input  logic [AW-1:0]      mem_dst,
  input  logic               mem_wr,
  input  logic               br_done,
  input  logic               br_miss,
  output logic               hold_fetch,
  output logic               kill_id,
  output logic               kill_ex,
  output logic               kill_mem,
  output logic               redirect
);
  import phc_pkg::*;

  logic     raw_hit;
  logic     wrong_path;
  phc_ctl_t ctl;

  phc_raw_detect #(.AW(AW), .NSRC(NSRC)) u_raw (
    .id_src     (id_src),
    .id_src_use (id_src_use),
    .ex_dst     (ex_dst),
    .ex_wr      (ex_wr),
    .mem_dst    (mem_dst),
    .mem_wr     (mem_wr),
    .raw_hit    (raw_hit)
  );

  phc_redirect u_br (
    .br_done    (br_done),
    .br_miss    (br_miss),
    .wrong_path (wrong_path)
  );

  // A flush beats a stall: the held decode instruction is on the wrong path.
  always_comb begin
    ctl            = '0;
    ctl.hold_fetch = raw_hit & ~wrong_path;
    ctl.kill_id    = wrong_path;
    ctl.kill_ex    = raw_hit | wrong_path;
    ctl.kill_mem   = wrong_path;
    ctl.redirect   = wrong_path;
  end

  assign hold_fetch = ctl.hold_fetch;
  assign kill_id    = ctl.kill_id;
  assign kill_ex    = ctl.kill_ex;
  assign kill_mem   = ctl.kill_mem;
  assign redirect   = ctl.redirect;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_chk #(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input logic [NSRC*AW-1:0] id_src,
  input logic [NSRC-1:0]    id_src_use,
  input logic [AW-1:0]      ex_dst,
  input logic               ex_wr,
  input logic [AW-1:0]      mem_dst,
  input logic               mem_wr,
  input logic               br_done,
  input logic               br_miss,
  input logic               hold_fetch,
  input logic               kill_id,
  input logic               kill_ex,
  input logic               kill_mem,
  input logic               redirect
);
  logic known;

  always_comb begin
    known = !$isunknown({id_src, id_src_use, ex_dst, ex_wr, mem_dst, mem_wr,
                         br_done, br_miss, hold_fetch, kill_id, kill_ex,
                         kill_mem, redirect});
    if (known) begin
      // R1
      hold_bubble_chk: assert (!hold_fetch || kill_ex)
        else $error("hold without bubble");
      // R4
      zero_dst_chk: assert (!(ex_dst == '0 && mem_dst == '0) || !hold_fetch)
        else $error("stall on register 0");
      // R5
      no_writer_chk: assert ((ex_wr || mem_wr) || !hold_fetch)
        else $error("stall without writer");
      // R5
      no_use_chk: assert (id_src_use != '0 || !hold_fetch)
        else $error("stall without used source");
      // R7
      good_branch_chk: assert (!(br_done && !br_miss) || !(kill_id || kill_mem || redirect))
        else $error("flush on correct branch");
      // R8
      bad_branch_chk: assert (!(br_done && br_miss) || (kill_id && kill_ex && kill_mem && redirect))
        else $error("missing flush");
      // R9
      flush_wins_chk: assert (!redirect || !hold_fetch)
        else $error("hold during redirect");
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src_chk
    always_comb begin
      if (known) begin
        // R1
        ex_dep_chk: assert (!(id_src_use[s] && ex_wr && ex_dst != '0 &&
                              id_src[s*AW +: AW] == ex_dst && !(br_done && br_miss)) || hold_fetch)
          else $error("missed execute dependency");
        // R2
        mem_dep_chk: assert (!(id_src_use[s] && mem_wr && mem_dst != '0 &&
                               id_src[s*AW +: AW] == mem_dst && !(br_done && br_miss)) || hold_fetch)
          else $error("missed memory dependency");
      end
    end
  end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.AW(AW), .NSRC(NSRC)) u_chk (
  .id_src     (id_src),
  .id_src_use (id_src_use),
  .ex_dst     (ex_dst),
  .ex_wr      (ex_wr),
  .mem_dst    (mem_dst),
  .mem_wr     (mem_wr),
  .br_done    (br_done),
  .br_miss    (br_miss),
  .hold_fetch (hold_fetch),
  .kill_id    (kill_id),
  .kill_ex    (kill_ex),
  .kill_mem   (kill_mem),
  .redirect   (redirect)
);

// File: tb/pipe_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb;
  localparam int unsigned AW   = 2;
  localparam int unsigned NSRC = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [NSRC*AW-1:0] id_src;
  logic [NSRC-1:0]    id_src_use;
  logic [AW-1:0]      ex_dst, mem_dst;
  logic               ex_wr, mem_wr, br_done, br_miss;
  logic               hold_fetch, kill_id, kill_ex, kill_mem, redirect;

  pipe_hazard_ctrl #(.AW(AW), .NSRC(NSRC)) u_dut (
    .id_src(id_src), .id_src_use(id_src_use), .ex_dst(ex_dst), .ex_wr(ex_wr),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .br_done(br_done), .br_miss(br_miss),
    .hold_fetch(hold_fetch), .kill_id(kill_id), .kill_ex(kill_ex),
    .kill_mem(kill_mem), .redirect(redirect)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {hold_fetch, kill_id, kill_ex, kill_mem, redirect};
  endfunction

  // Model program for stream runs: destination, write flag, source and use flag.
  int p_dst[4], p_wr[4], p_src[4], p_use[4];
  int p_len;

  task automatic run_stream(input string tag, input int exp_stalls);
    int id_i = -1, ex_i = -1, mem_i = -1, pc = 0, stalls = 0;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(posedge clk);
      id_src     = (id_i >= 0) ? {2'b00, p_src[id_i][1:0]} : '0;
      id_src_use = (id_i >= 0) ? {1'b0, p_use[id_i] != 0} : '0;
      ex_dst     = (ex_i >= 0) ? p_dst[ex_i][1:0] : '0;
      ex_wr      = (ex_i >= 0) ? (p_wr[ex_i] != 0) : 1'b0;
      mem_dst    = (mem_i >= 0) ? p_dst[mem_i][1:0] : '0;
      mem_wr     = (mem_i >= 0) ? (p_wr[mem_i] != 0) : 1'b0;
      br_done    = 1'b0;
      br_miss    = 1'b0;
      @(negedge clk);
      mem_i = ex_i;
      if (hold_fetch) begin
        stalls++;
        ex_i = -1;
      end else begin
        ex_i = id_i;
        id_i = (pc < p_len) ? pc : -1;
        pc++;
      end
    end
    check(tag, stalls, exp_stalls);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    id_src = '0; id_src_use = '0; ex_dst = '0; ex_wr = 0;
    mem_dst = '0; mem_wr = 0; br_done = 0; br_miss = 0;
    @(negedge clk);
    // R3 idle state with quiet inputs
    check("R3", outs(), 5'b00000);

    for (int code = 0; code < (1 << 14); code++) begin
      logic [13:0] c;
      logic hit0x, hit0m, hit1x, hit1m, dep, miss, zero_case, nowr_case;
      logic [4:0] exp;
      string tag;
      c = code[13:0];
      @(posedge clk);
      id_src = c[3:0]; id_src_use = c[5:4]; ex_dst = c[7:6]; ex_wr = c[8];
      mem_dst = c[10:9]; mem_wr = c[11]; br_done = c[12]; br_miss = c[13];
      hit0x = c[4] && c[8]  && c[7:6]  != 0 && c[1:0] == c[7:6];
      hit0m = c[4] && c[11] && c[10:9] != 0 && c[1:0] == c[10:9];
      hit1x = c[5] && c[8]  && c[7:6]  != 0 && c[3:2] == c[7:6];
      hit1m = c[5] && c[11] && c[10:9] != 0 && c[3:2] == c[10:9];
      dep  = hit0x | hit0m | hit1x | hit1m;
      miss = c[12] & c[13];
      exp  = {dep & ~miss, miss, dep | miss, miss, miss};
      zero_case = (c[4] && c[1:0] == 0 && ((c[8] && c[7:6] == 0) || (c[11] && c[10:9] == 0))) ||
                  (c[5] && c[3:2] == 0 && ((c[8] && c[7:6] == 0) || (c[11] && c[10:9] == 0)));
      nowr_case = (!c[8] && (c[1:0] == c[7:6] || c[3:2] == c[7:6])) ||
                  (!c[11] && (c[1:0] == c[10:9] || c[3:2] == c[10:9])) || c[5:4] == 0;
      if (miss && dep)             tag = "R9";
      else if (miss)               tag = "R8";
      else if (c[12])              tag = "R7";
      else if (dep && !(hit0x | hit0m)) tag = "R10";
      else if (hit0x | hit1x)      tag = "R1";
      else if (dep)                tag = "R2";
      else if (zero_case)          tag = "R4";
      else if (nowr_case)          tag = "R5";
      else if (c[13])              tag = "R8";
      else                         tag = "R3";
      @(negedge clk);
      check(tag, outs(), exp);
    end

    // R6 stream runs: producer writes register 1, fillers write nothing
    for (int d = 1; d <= 3; d++) begin
      p_len = d + 1;
      for (int k = 0; k < 4; k++) begin p_dst[k] = 0; p_wr[k] = 0; p_src[k] = 0; p_use[k] = 0; end
      p_dst[0] = 1; p_wr[0] = 1;
      p_src[d] = 1; p_use[d] = 1;
      run_stream("R6", 3 - d);
    end
    // R6 two consumers back to back share the producer's stall
    p_len = 3;
    for (int k = 0; k < 4; k++) begin p_dst[k] = 0; p_wr[k] = 0; p_src[k] = 0; p_use[k] = 0; end
    p_dst[0] = 1; p_wr[0] = 1;
    p_src[1] = 1; p_use[1] = 1;
    p_src[2] = 1; p_use[2] = 1;
    run_stream("R6", 2);
    // R4 producer aimed at register 0 never stalls the stream
    p_dst[0] = 0; p_src[1] = 0; p_src[2] = 0;
    run_stream("R4", 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule